// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a synchronous binary counter built from a parameterised number of 4-bit stages. On each rising clock edge it either loads a parallel word, steps up or down by one, or keeps its value. The count wraps at the full chain width in both directions. The direction input and the parallel-load input are shared by every stage.

Each stage produces an active-low terminal-count signal, and that signal drives the carry enable of the stage above it. A stage's terminal value is all ones when counting up and all zeros when counting down. The last stage's terminal-count signal is brought out as the block's ripple output, so further blocks can be chained onto it.

Counting needs both active-low enables to be low. The carry enable also gates the terminal-count output, and that output is combinational, so it follows the carry enable and direction inputs within the same cycle. A synchronous active-high reset puts the counter into a known state.

Top module: `casc_updown_counter`

## Requirements
- R1: When `rst` is high at a rising edge, the count becomes zero on that edge. This takes priority over a load and over counting.
- R2: When `rst` is low and `load_n` is low at a rising edge, `count` takes the value of `din`. The levels of `cnt_en_n` and `carry_en_n` do not matter.
- R3: When `rst` is low, `load_n` is high, `cnt_en_n` and `carry_en_n` are both low, and `up` is 1, `count` increments by one. It wraps from all ones to zero.
- R4: Under the same enable conditions with `up` at 0, `count` decrements by one. It wraps from zero to all ones.
- R5: When `load_n` is high and either `cnt_en_n` or `carry_en_n` is high, `count` keeps its value.
- R6: `tc_n` is low only when `carry_en_n` is low and `count` is at the terminal value for the present `up` level. The terminal value is all ones for `up`=1 and all zeros for `up`=0. In every other case `tc_n` is high. It changes in the same cycle as its inputs, with no clock edge needed.
- R7: Between stages, nibble k+1 steps only when every lower nibble is at its terminal value. For example, 0x0F counts up to 0x10, and 0x10 counts down to 0x0F.
- R8: Loading 12 and counting up gives 13, 14, 15 and then carries on through the wider count. When an enable is raised, the value holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| load_n | input | 1 | Active-low parallel load |
| cnt_en_n | input | 1 | Active-low count enable (does not gate tc_n) |
| carry_en_n | input | 1 | Active-low carry enable (gates tc_n) |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | 4*STAGES | Parallel load word |
| count | output | 4*STAGES | Current count |
| tc_n | output | 1 | Active-low terminal count of the last stage |

## Verification
The assertions assume that every control input and `din` is settled and known at each rising edge, and that `rst` is high at the first edge so the stage registers start from a known value. The clocked checks are disabled while reset is high. The stimulus changes inputs only at falling edges and begins with a reset cycle, so every sampled edge meets these assumptions. Direction flips while the count sits at a terminal value are checked against a model of the chain width on every edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    localparam int NIB_W = 4;

    typedef logic [NIB_W-1:0] nib_t;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_LOAD,
        OP_INC,
        OP_DEC
    } op_e;

    typedef struct packed {
        logic load_n;
        logic cnt_n;
        logic carry_n;
        logic up;
    } ctl_t;

    // Load wins over counting; counting needs both enables low.
    function automatic op_e decode_op(input ctl_t c);
        if (!c.load_n)
            return OP_LOAD;
        else if (!c.cnt_n && !c.carry_n)
            return c.up ? OP_INC : OP_DEC;
        else
            return OP_HOLD;
    endfunction

    function automatic nib_t end_value(input logic up);
        return up ? {NIB_W{1'b1}} : {NIB_W{1'b0}};
    endfunction

endpackage

// File: rtl/nibble_step.sv
module nibble_step
    import cnt_pkg::*;
(
    input  op_e  op,
    input  nib_t cur,
    input  nib_t ld,
    output nib_t nxt
);
    always_comb begin
        unique case (op)
            OP_LOAD: nxt = ld;
            OP_INC:  nxt = cur + nib_t'(1);
            OP_DEC:  nxt = cur - nib_t'(1);
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/nibble_tc.sv
module nibble_tc
    import cnt_pkg::*;
(
    input  nib_t cur,
    input  logic up,
    input  logic carry_n,
    output logic tc_n
);
    logic at_end;

    always_comb begin
        at_end = (cur == end_value(up));
        tc_n   = !(at_end && !carry_n);
    end
endmodule

// File: rtl/nibble_stage.sv
module nibble_stage
    import cnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl,
    input  nib_t ld,
    output nib_t q,
    output logic tc_n
);
    op_e  op;
    nib_t nxt;

    always_comb op = decode_op(ctl);

    nibble_step u_step (
        .op  (op),
        .cur (q),
        .ld  (ld),
        .nxt (nxt)
    );

    nibble_tc u_tc (
        .cur     (q),
        .up      (ctl.up),
        .carry_n (ctl.carry_n),
        .tc_n    (tc_n)
    );

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= nxt;
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        !ctl.load_n |=> q == $past(ld));

    assert_inc_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl.load_n && !ctl.cnt_n && !ctl.carry_n && ctl.up)
        |=> q == nib_t'($past(q) + nib_t'(1)));

    assert_dec_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl.load_n && !ctl.cnt_n && !ctl.carry_n && !ctl.up)
        |=> q == nib_t'($past(q) - nib_t'(1)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl.load_n && (ctl.cnt_n || ctl.carry_n)) |=> $stable(q));

    assert_tc_gate_R6: assert property (@(posedge clk) disable iff (rst)
        !tc_n |-> (!ctl.carry_n && (q == end_value(ctl.up))));
endmodule

// File: rtl/casc_updown_counter.sv
module casc_updown_counter
    import cnt_pkg::*;
#(
    parameter int STAGES = 2,
    localparam int W = STAGES * NIB_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic         cnt_en_n,
    input  logic         carry_en_n,
    input  logic         up,
    input  logic [W-1:0] din,
    output logic [W-1:0] count,
    output logic         tc_n
);
    // chain[k] is the carry enable seen by stage k
    logic [STAGES:0] chain;

    assign chain[0] = carry_en_n;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        ctl_t c;
        nib_t q;

        always_comb begin
            c.load_n  = load_n;
            c.cnt_n   = cnt_en_n;
            c.carry_n = chain[k];
            c.up      = up;
        end

        nibble_stage u_stage (
            .clk  (clk),
            .rst  (rst),
            .ctl  (c),
            .ld   (din[k*NIB_W +: NIB_W]),
            .q    (q),
            .tc_n (chain[k+1])
        );

        assign count[k*NIB_W +: NIB_W] = q;
    end

    assign tc_n = chain[STAGES];

    assert_clear_R1: assert property (@(posedge clk)
        rst |=> count == '0);

    assert_wide_inc_R7: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && !carry_en_n && up)
        |=> count == W'($past(count) + W'(1)));

    assert_wide_dec_R7: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && !carry_en_n && !up)
        |=> count == W'($past(count) - W'(1)));
endmodule

// File: tb/test_casc_updown_counter.sv
module test_casc_updown_counter;
    localparam int STAGES = 2;
    localparam int W = STAGES * 4;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_n = 1'b1;
    logic         cnt_en_n = 1'b1;
    logic         carry_en_n = 1'b1;
    logic         up = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] count;
    logic         tc_n;

    int n_checks = 0;
    int n_fail   = 0;
    logic [W-1:0] model = '0;

    always #4 clk = ~clk;

    casc_updown_counter #(.STAGES(STAGES)) i_casc_updown_counter (
        .clk        (clk),
        .rst        (rst),
        .load_n     (load_n),
        .cnt_en_n   (cnt_en_n),
        .carry_en_n (carry_en_n),
        .up         (up),
        .din        (din),
        .count      (count),
        .tc_n       (tc_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic model_tc(input logic c, input logic u, input logic [W-1:0] m);
        return !(!c && (u ? (m == ONES) : (m == '0)));
    endfunction

    // Drive at falling edge, check tc_n before the edge, then the count after it.
    task automatic step(input logic r, input logic ld, input logic p, input logic c,
                        input logic u, input logic [W-1:0] d, input string tag);
        @(negedge clk);
        rst = r; load_n = ld; cnt_en_n = p; carry_en_n = c; up = u; din = d;
        #1;
        if (!r) check("R6 tc_n", {31'd0, tc_n}, {31'd0, model_tc(c, u, model)});
        @(posedge clk);
        if (r)                model = '0;
        else if (!ld)         model = d;
        else if (!p && !c)    model = u ? model + W'(1) : model - W'(1);
        #1;
        check(tag, {{(32-W){1'b0}}, count}, {{(32-W){1'b0}}, model});
    endtask

    task automatic t_reset;
        step(1, 0, 0, 0, 1, 8'hA5, "R1 reset overrides load");
        step(0, 1, 1, 1, 1, '0, "R1 stays zero");
    endtask

    task automatic t_load;
        step(0, 0, 1, 1, 1, 8'h3C, "R2 load with enables high");
        step(0, 0, 0, 0, 0, 8'hC3, "R2 load with enables low");
    endtask

    task automatic t_example;
        step(0, 0, 1, 1, 1, 8'h0C, "R8 load 12");
        for (int i = 0; i < 6; i++) step(0, 1, 0, 0, 1, '0, "R8 R3 count up");
        step(0, 1, 1, 0, 1, '0, "R8 R5 hold via cnt_en_n");
        step(0, 1, 0, 1, 1, '0, "R8 R5 hold via carry_en_n");
    endtask

    task automatic t_wrap;
        step(0, 0, 1, 1, 1, ONES - W'(1), "R2 load near top");
        step(0, 1, 0, 0, 1, '0, "R3 to all ones");
        step(0, 1, 0, 0, 1, '0, "R3 wrap to zero");
        step(0, 1, 0, 0, 0, '0, "R4 wrap to all ones");
        step(0, 1, 0, 0, 0, '0, "R4 down");
    endtask

    task automatic t_cross;
        step(0, 0, 1, 1, 1, 8'h0F, "R2 load 0x0F");
        step(0, 1, 0, 0, 1, '0, "R7 up carry into upper nibble");
        step(0, 1, 0, 0, 0, '0, "R7 down borrow from upper nibble");
        step(0, 1, 0, 0, 0, '0, "R7 lower nibble only");
    endtask

    task automatic t_tc_carry;
        step(0, 0, 1, 1, 1, ONES, "R2 load all ones");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            carry_en_n = i[0]; up = i[1] ? 1'b1 : 1'b0;
            load_n = 1'b1; cnt_en_n = 1'b1; #1;
            check("R6 immediate tc_n", {31'd0, tc_n}, {31'd0, model_tc(carry_en_n, up, model)});
        end
        step(0, 0, 1, 1, 0, '0, "R2 load zero");
        step(0, 1, 1, 0, 0, '0, "R6 R5 down terminal, hold");
    endtask

    task automatic t_random_dir;
        for (int i = 0; i < 60; i++) begin
            logic [W-1:0] d;
            d = ($urandom_range(0, 1) == 1) ? ONES : '0;
            if (i % 8 == 0)
                step(0, 0, 1, 1, 1'($urandom_range(0, 1)), d, "R2 random terminal load");
            else
                step(0, 1, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
                     1'($urandom_range(0, 1)), '0, "R3 R4 R5 random direction");
        end
    endtask

    initial begin
        #(200000 * 8);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_example();
        t_wrap();
        t_cross();
        t_tc_carry();
        t_random_dir();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule